// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block resolves read-after-write dependencies in an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback). A combinational hazard unit compares the source register fields of the instruction in the decode/execute latch against the destination fields of the two older instructions in the execute/memory and memory/writeback latches. It drives the select lines of the two ALU operand multiplexers. When a load's result is needed by the very next instruction, it raises a stall: the PC and the decode latch hold and a no-operation bubble enters execute. Write-after-write, write-after-read and read-after-read pairs need no action, because issue and completion stay in order.

Around the unit sits a compact pipeline: a register file that writes before it reads, an ALU stub, and a data-memory stub. The stub returns the load address XORed with a fixed key. This lets the resolved operands be checked against architectural values. Instructions arrive on `instr_in` from an external store indexed by `pc`.

Instruction word (19 bits with defaults): `[18:17]` opcode, `[16:14]` rd, `[13:11]` rs1, `[10:8]` rs2, `[7:0]` imm. Opcodes: `00` no-op, `01` add (rd = rs1 + rs2), `10` load (rd = (rs1 + imm) ^ MEM_KEY, with MEM_KEY = 16'h5A5A), `11` load-immediate (rd = imm). Add reads rs1 and rs2, load reads rs1 only, and the other opcodes read nothing.

Top module: `fwd_pipe_top`

## Requirements
- R1: Each opcode writes its result, as defined in the instruction word description, to rd; the write appears on `wb_we`/`wb_rd`/`wb_data` four cycles after fetch (without stalls); a write to x0 or a no-op never asserts `wb_we`.
- R2: When the instruction in execute reads a register written by the non-load instruction one ahead of it, that operand's select is 2'b10 and the operand equals the architectural value.
- R3: When the producer is two ahead (in memory/writeback), the select is 2'b01 and the operand equals the architectural value; this includes load results.
- R4: When both older stages write the same source register, the execute/memory result wins (select 2'b10).
- R5: A source field of x0 never forwards (select 2'b00) and reads as zero; an older instruction with no register write never forwards.
- R6: A load followed immediately by an instruction that reads its rd stalls exactly one cycle: `stall` is 1, `pc` holds, and the next cycle's execute holds a bubble; afterwards the operand resolves from memory/writeback.
- R7: A producer three ahead of its consumer is seen through the register file's write-then-read behaviour, with select 2'b00 and the correct value.
- R8: Out of reset, `pc` is 0, `stall` is 0 and `wb_we` is 0; without a stall, `pc` advances by one every cycle.
- R9: Source fields that an opcode does not read (both for load-immediate, rs2 for load) cause neither forwarding nor a stall.
- R10: No stall is raised except for the load-use case of R6, so write-after-write, write-after-read and read-after-read sequences run at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_in | input | 19 | Instruction fetched at `pc` |
| pc | output | 6 | Instruction index being fetched |
| stall | output | 1 | Load-use stall: PC and decode hold, bubble into execute |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| ex_opa | output | 16 | Resolved operand A in execute |
| ex_opb | output | 16 | Resolved operand B in execute |
| wb_we | output | 1 | Register write this cycle |
| wb_rd | output | 3 | Register written |
| wb_data | output | 16 | Value written |

## Verification
The bench builds the block with its defaults: 16-bit data, eight registers, 8-bit immediates and a 6-bit PC. With only eight registers, a short program can make a source match one older stage, both older stages, x0, or an unread field. It can also chain load after load and place producers exactly one, two and three slots ahead. A behavioural model keeps architectural registers and its own view of the pipeline. Each cycle it predicts the stall, both selects, the resolved operands and the writeback.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_EXM = 2'b10
    } fwd_src_e;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ADD = 2'b01,
        OP_LD  = 2'b10,
        OP_LI  = 2'b11
    } fwd_op_e;

    function automatic logic reads_rs1(fwd_op_e op);
        return (op == OP_ADD) || (op == OP_LD);
    endfunction

    function automatic logic reads_rs2(fwd_op_e op);
        return (op == OP_ADD);
    endfunction

endpackage

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int RAW = 3
) (
    input  logic [1:0][RAW-1:0] dec_rs,
    input  logic [1:0]          dec_use,
    input  logic [RAW-1:0]      ex_rd,
    input  logic                ex_we,
    input  logic                ex_load,
    input  logic [1:0][RAW-1:0] ex_rs,
    input  logic [1:0]          ex_use,
    input  logic [RAW-1:0]      mem_rd,
    input  logic                mem_we,
    input  logic                mem_load,
    input  logic [RAW-1:0]      wb_rd,
    input  logic                wb_we,
    output fwd_src_e            sel [2],
    output logic                stall
);

    logic [1:0] dec_hit;

    for (genvar g = 0; g < 2; g++) begin : g_port
        logic src_live;
        logic hit_mem;
        logic hit_wb;

        assign src_live = ex_use[g] && (ex_rs[g] != '0);
        assign hit_mem  = src_live && mem_we && !mem_load && (mem_rd == ex_rs[g]);
        assign hit_wb   = src_live && wb_we && (wb_rd == ex_rs[g]);

        always_comb begin
            unique case ({hit_mem, hit_wb})
                2'b10, 2'b11: sel[g] = SRC_EXM;
                2'b01:        sel[g] = SRC_WB;
                default:      sel[g] = SRC_RF;
            endcase
        end

        assign dec_hit[g] = dec_use[g] && (dec_rs[g] == ex_rd);
    end

    assign stall = ex_load && ex_we && (|dec_hit);

endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
    parameter int XLEN = 16,
    parameter int RAW  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [RAW-1:0]      waddr,
    input  logic [XLEN-1:0]     wdata,
    input  logic [1:0][RAW-1:0] raddr,
    output logic [1:0][XLEN-1:0] rdata
);

    localparam int NREG = 1 << RAW;

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0)
                rdata[p] = '0;
            else if (we && (waddr == raddr[p]))
                rdata[p] = wdata;
            else
                rdata[p] = regs[raddr[p]];
        end
    end

endmodule

// File: rtl/fwd_alu.sv
module fwd_alu
    import fwd_pkg::*;
#(
    parameter int XLEN = 16,
    parameter int IMMW = 8
) (
    input  fwd_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] y
);

    logic [XLEN-1:0] imm_x;
    assign imm_x = {{(XLEN-IMMW){1'b0}}, imm};

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_LD:   y = a + imm_x;
            OP_LI:   y = imm_x;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/fwd_pipe_top.sv
module fwd_pipe_top
    import fwd_pkg::*;
#(
    parameter int              XLEN    = 16,
    parameter int              RAW     = 3,
    parameter int              IMMW    = 8,
    parameter int              PCW     = 6,
    parameter logic [XLEN-1:0] MEM_KEY = 16'h5A5A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2+3*RAW+IMMW-1:0] instr_in,
    output logic [PCW-1:0]        pc,
    output logic                  stall,
    output logic [1:0]            fwd_sel_a,
    output logic [1:0]            fwd_sel_b,
    output logic [XLEN-1:0]       ex_opa,
    output logic [XLEN-1:0]       ex_opb,
    output logic                  wb_we,
    output logic [RAW-1:0]        wb_rd,
    output logic [XLEN-1:0]       wb_data
);

    localparam int IW     = 2 + 3*RAW + IMMW;
    localparam int OP_LSB = IW - 2;
    localparam int RD_LSB = OP_LSB - RAW;
    localparam int S1_LSB = RD_LSB - RAW;
    localparam int S2_LSB = S1_LSB - RAW;

    // Decode stage
    logic [IW-1:0]          ifid_instr;
    fwd_op_e                dec_op;
    logic [RAW-1:0]         dec_rd;
    logic [1:0][RAW-1:0]    dec_rs;
    logic [1:0]             dec_use;
    logic [IMMW-1:0]        dec_imm;
    logic [1:0][XLEN-1:0]   dec_rv;

    // Execute stage latch
    fwd_op_e                idex_op;
    logic [RAW-1:0]         idex_rd;
    logic [1:0][RAW-1:0]    idex_rs;
    logic [1:0]             idex_use;
    logic [IMMW-1:0]        idex_imm;
    logic [1:0][XLEN-1:0]   idex_rv;
    logic                   idex_we;

    // Memory stage latch
    logic                   exm_we;
    logic                   exm_load;
    logic [RAW-1:0]         exm_rd;
    logic [XLEN-1:0]        exm_res;
    logic [XLEN-1:0]        mem_data;

    fwd_src_e               sel [2];
    logic [1:0][XLEN-1:0]   opnd;
    logic [XLEN-1:0]        alu_y;

    assign dec_op     = fwd_op_e'(ifid_instr[OP_LSB +: 2]);
    assign dec_rd     = ifid_instr[RD_LSB +: RAW];
    assign dec_rs[0]  = ifid_instr[S1_LSB +: RAW];
    assign dec_rs[1]  = ifid_instr[S2_LSB +: RAW];
    assign dec_imm    = ifid_instr[IMMW-1:0];
    assign dec_use[0] = reads_rs1(dec_op);
    assign dec_use[1] = reads_rs2(dec_op);

    fwd_regfile #(.XLEN(XLEN), .RAW(RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .waddr (wb_rd),
        .wdata (wb_data),
        .raddr (dec_rs),
        .rdata (dec_rv)
    );

    fwd_hazard_unit #(.RAW(RAW)) u_haz (
        .dec_rs   (dec_rs),
        .dec_use  (dec_use),
        .ex_rd    (idex_rd),
        .ex_we    (idex_we),
        .ex_load  (idex_op == OP_LD),
        .ex_rs    (idex_rs),
        .ex_use   (idex_use),
        .mem_rd   (exm_rd),
        .mem_we   (exm_we),
        .mem_load (exm_load),
        .wb_rd    (wb_rd),
        .wb_we    (wb_we),
        .sel      (sel),
        .stall    (stall)
    );

    // Operand multiplexers
    for (genvar g = 0; g < 2; g++) begin : g_mux
        always_comb begin
            unique case (sel[g])
                SRC_EXM: opnd[g] = exm_res;
                SRC_WB:  opnd[g] = wb_data;
                default: opnd[g] = idex_rv[g];
            endcase
        end
    end

    fwd_alu #(.XLEN(XLEN), .IMMW(IMMW)) u_alu (
        .op  (idex_op),
        .a   (opnd[0]),
        .b   (opnd[1]),
        .imm (idex_imm),
        .y   (alu_y)
    );

    assign mem_data = exm_load ? (exm_res ^ MEM_KEY) : exm_res;

    // Front end: PC and decode latch hold on stall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc         <= '0;
            ifid_instr <= '0;
        end else if (!stall) begin
            pc         <= pc + 1'b1;
            ifid_instr <= instr_in;
        end
    end

    // Execute latch: bubble on stall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idex_op  <= OP_NOP;
            idex_rd  <= '0;
            idex_rs  <= '0;
            idex_use <= '0;
            idex_imm <= '0;
            idex_rv  <= '0;
            idex_we  <= 1'b0;
        end else if (stall) begin
            idex_op  <= OP_NOP;
            idex_rd  <= '0;
            idex_rs  <= '0;
            idex_use <= '0;
            idex_imm <= '0;
            idex_rv  <= '0;
            idex_we  <= 1'b0;
        end else begin
            idex_op  <= dec_op;
            idex_rd  <= dec_rd;
            idex_rs  <= dec_rs;
            idex_use <= dec_use;
            idex_imm <= dec_imm;
            idex_rv  <= dec_rv;
            idex_we  <= (dec_op != OP_NOP) && (dec_rd != '0);
        end
    end

    // Memory and writeback latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exm_we   <= 1'b0;
            exm_load <= 1'b0;
            exm_rd   <= '0;
            exm_res  <= '0;
            wb_we    <= 1'b0;
            wb_rd    <= '0;
            wb_data  <= '0;
        end else begin
            exm_we   <= idex_we;
            exm_load <= (idex_op == OP_LD);
            exm_rd   <= idex_rd;
            exm_res  <= alu_y;
            wb_we    <= exm_we;
            wb_rd    <= exm_rd;
            wb_data  <= mem_data;
        end
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];
    assign ex_opa    = opnd[0];
    assign ex_opb    = opnd[1];

    // Checks on stage-to-stage behaviour
    assert_pc_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    assert_bubble_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !idex_we);

    assert_pc_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (pc == $past(pc) + 1'b1));

    assert_no_load_use_in_ex_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_load && exm_we) |->
            !((idex_use[0] && idex_rs[0] == exm_rd) || (idex_use[1] && idex_rs[1] == exm_rd)));

    assert_x0_not_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rs[0] == '0) |-> (fwd_sel_a == 2'b00));

    assert_wb_write_has_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_rd != '0));

endmodule

// File: tb/fwd_pipe_top_bench.sv
`timescale 1ns/1ps
module fwd_pipe_top_bench;

    localparam int IW = 19;

    logic          clk;
    logic          rst_n;
    logic [IW-1:0] instr_in;
    logic [5:0]    pc;
    logic          stall;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic [15:0]   ex_opa, ex_opb, wb_data;
    logic          wb_we;
    logic [2:0]    wb_rd;

    logic [IW-1:0] prog [64];

    int n_chk = 0;
    int n_fail = 0;

    fwd_pipe_top u_fwd_pipe_top (
        .clk(clk), .rst_n(rst_n), .instr_in(instr_in), .pc(pc), .stall(stall),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .ex_opa(ex_opa), .ex_opb(ex_opb),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    assign instr_in = prog[pc];

    function automatic logic [IW-1:0] mk(int op, int rd, int s1, int s2, int imm);
        return {op[1:0], rd[2:0], s1[2:0], s2[2:0], imm[7:0]};
    endfunction

    function automatic int f_op(logic [IW-1:0] w);  return int'(w[18:17]); endfunction
    function automatic int f_rd(logic [IW-1:0] w);  return int'(w[16:14]); endfunction
    function automatic int f_s1(logic [IW-1:0] w);  return int'(w[13:11]); endfunction
    function automatic int f_s2(logic [IW-1:0] w);  return int'(w[10:8]);  endfunction
    function automatic int f_imm(logic [IW-1:0] w); return int'(w[7:0]);   endfunction
    function automatic bit f_u1(logic [IW-1:0] w); return f_op(w) == 1 || f_op(w) == 2; endfunction
    function automatic bit f_u2(logic [IW-1:0] w); return f_op(w) == 1; endfunction
    function automatic bit f_we(logic [IW-1:0] w); return f_op(w) != 0 && f_rd(w) != 0; endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle pc model %0d)", tag, act, exp, m_pc);
        end
    endtask

    // Behavioural reference: architectural registers plus stage occupancy
    int            arch [8];
    logic [IW-1:0] m_ifid, m_idex, m_exm, m_wb;
    int            m_exm_res, m_wb_res;
    int            m_pc;

    function automatic int exp_sel(logic [IW-1:0] w, int idx);
        int s;
        bit used;
        s    = (idx == 0) ? f_s1(w) : f_s2(w);
        used = (idx == 0) ? f_u1(w) : f_u2(w);
        if (!used || s == 0) return 0;                                     // R5, R9
        if (f_we(m_exm) && f_rd(m_exm) == s && f_op(m_exm) != 2) return 2; // R2, R4
        if (f_we(m_wb) && f_rd(m_wb) == s) return 1;                       // R3
        return 0;                                                          // R7
    endfunction

    function automatic bit exp_stall();
        int d;
        if (f_op(m_idex) != 2 || !f_we(m_idex)) return 1'b0;               // R10
        d = f_rd(m_idex);
        return (f_u1(m_ifid) && f_s1(m_ifid) == d) || (f_u2(m_ifid) && f_s2(m_ifid) == d);
    endfunction

    task automatic compare_cycle();
        chk("R8 pc", int'(pc), m_pc);
        chk("R6/R10 stall", int'(stall), int'(exp_stall()));
        chk("R2/R3/R4/R5 sel_a", int'(fwd_sel_a), exp_sel(m_idex, 0));
        chk("R2/R3/R4/R5 sel_b", int'(fwd_sel_b), exp_sel(m_idex, 1));
        if (f_u1(m_idex)) chk("R2/R3/R7 opa", int'(ex_opa), arch[f_s1(m_idex)]);
        if (f_u2(m_idex)) chk("R2/R3/R7 opb", int'(ex_opb), arch[f_s2(m_idex)]);
        chk("R1 wb_we", int'(wb_we), int'(f_we(m_wb)));
        if (f_we(m_wb)) begin
            chk("R1 wb_rd", int'(wb_rd), f_rd(m_wb));
            chk("R1 wb_data", int'(wb_data), m_wb_res);
        end
    endtask

    task automatic model_step();
        int res;
        bit st;
        st = exp_stall();
        case (f_op(m_idex))
            1: res = (arch[f_s1(m_idex)] + arch[f_s2(m_idex)]) & 16'hFFFF;
            2: res = ((arch[f_s1(m_idex)] + f_imm(m_idex)) & 16'hFFFF) ^ 16'h5A5A;
            3: res = f_imm(m_idex);
            default: res = 0;
        endcase
        if (f_we(m_idex)) arch[f_rd(m_idex)] = res;
        m_wb      = m_exm;
        m_wb_res  = m_exm_res;
        m_exm     = m_idex;
        m_exm_res = res;
        if (st) begin
            m_idex = '0;
        end else begin
            m_idex = m_ifid;
            m_ifid = prog[m_pc % 64];
            m_pc   = (m_pc + 1) % 64;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = '0;
        prog[0]  = mk(3, 1, 0, 0, 5);
        prog[1]  = mk(3, 2, 0, 0, 7);
        prog[2]  = mk(1, 3, 1, 2, 0);    // R2 on x2, R3 on x1
        prog[3]  = mk(1, 3, 3, 3, 0);    // R2 both operands
        prog[4]  = mk(1, 4, 3, 1, 0);    // R4: x3 in both older stages
        prog[5]  = mk(3, 0, 0, 0, 9);    // R1/R5: write to x0 dropped
        prog[6]  = mk(1, 5, 0, 4, 0);    // R5 x0 source, R3 on x4
        prog[7]  = mk(2, 6, 5, 0, 3);
        prog[8]  = mk(1, 7, 6, 1, 0);    // R6 load-use stall
        prog[9]  = mk(2, 1, 7, 0, 0);
        prog[11] = mk(1, 2, 1, 1, 0);    // R3 load two ahead, no stall
        prog[12] = mk(3, 3, 2, 2, 1);    // R9 unread fields match
        prog[13] = mk(2, 4, 3, 0, 4);
        prog[14] = mk(3, 5, 4, 4, 2);    // R9 no stall after load
        prog[15] = mk(1, 6, 4, 5, 0);    // R3 on load x4, R2 on x5
        prog[18] = mk(1, 7, 2, 3, 0);
        prog[19] = mk(3, 1, 0, 0, 4);
        prog[22] = mk(1, 2, 1, 0, 0);    // R7 producer three ahead
        prog[23] = mk(2, 3, 2, 0, 0);
        prog[24] = mk(1, 4, 3, 3, 0);    // R6 both sources
        prog[25] = mk(2, 5, 4, 0, 1);
        prog[26] = mk(2, 6, 5, 0, 0);    // R6 load consuming load
        prog[27] = mk(1, 7, 6, 6, 0);    // R6 again
        prog[28] = mk(1, 3, 3, 0, 0);    // R10 WAW/WAR on x3 at full rate
        prog[29] = mk(3, 3, 0, 0, 8);

        for (int i = 0; i < 8; i++) arch[i] = 0;
        m_ifid = '0; m_idex = '0; m_exm = '0; m_wb = '0;
        m_exm_res = 0; m_wb_res = 0; m_pc = 0;

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        chk("R8 reset pc", int'(pc), 0);
        chk("R8 reset stall", int'(stall), 0);
        chk("R8 reset wb_we", int'(wb_we), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 45; cyc++) begin
            compare_cycle();
            @(posedge clk);
            model_step();
            @(negedge clk);
        end
        // R1 final architectural values via the model's last writes
        chk("R1 final x3", arch[3], 8);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule